// File: doc/BRIEF.md
# Fixed Segment Address Translator

This block sits between a processor's load/store or fetch unit and the memory system. It turns a 32-bit virtual address into a physical address using fixed rules for each address segment. There is no TLB and there are no page tables. Along with the physical address it produces a cacheable attribute and an access-fault flag.

The lower half of the virtual space is the user segment. That segment is relocated by a fixed physical offset. The upper half is divided into four 512 MB kernel segments. The first two kernel segments both map onto the same physical window starting at zero, and they differ only in whether the access may be cached. Device registers are therefore reached through the uncached alias. The upper two kernel segments map straight through.

When a request is issued in user mode and its address has bit 31 set, the translator does not produce an address. Instead it raises the fault flag and records the offending virtual address, so that the consumer can take an exception. Requests arrive on a valid/ready handshake. Each result is registered and held until the consumer takes it, and the block sustains one translation per cycle.

Top module: `segx_translator`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and `fault_vaddr` is zero.
- R2: An address with bit 31 clear translates to `vaddr + 0x4000_0000` (modulo 2^32) with `rsp_cacheable` = 1, in either privilege mode.
- R3: In kernel mode, an address whose bits [31:29] are 3'b100 translates to the address with bits [31:29] forced to zero, with `rsp_cacheable` = 1.
- R4: In kernel mode, an address whose bits [31:29] are 3'b101 translates to the address with bits [31:29] forced to zero, with `rsp_cacheable` = 0.
- R5: Two kernel-mode addresses in the 3'b100 and 3'b101 segments that share bits [28:0] yield the same physical address.
- R6: In kernel mode, an address whose bits [31:30] are 2'b11 passes through unchanged, with `rsp_cacheable` = 1.
- R7: In user mode (`req_user` = 1), an address with bit 31 set yields `rsp_fault` = 1, `rsp_paddr` = 0 and `rsp_cacheable` = 0.
- R8: `rsp_fault` is 0 for every kernel-mode request and for every user-mode request with bit 31 clear.
- R9: A result appears on the outputs in the cycle after its request is accepted. While `rsp_valid` = 1 and `rsp_ready` = 0, the result stays unchanged and `req_ready` is 0.
- R10: While `rsp_ready` stays at 1, a new request is accepted on every cycle, and each result follows its request by exactly one cycle.
- R11: On each accepted request, `fault_vaddr` loads the request's virtual address if that request faults, and loads zero otherwise. Between accepted requests it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present |
| req_ready | output | 1 | The translator can accept a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 = user privilege, 0 = kernel privilege |
| rsp_valid | output | 1 | A translation result is present |
| rsp_ready | input | 1 | The consumer takes the result this cycle |
| rsp_paddr | output | 32 | Physical address; zero when the request faulted |
| rsp_cacheable | output | 1 | The access may be cached |
| rsp_fault | output | 1 | Privilege violation; no memory access may be issued |
| fault_vaddr | output | 32 | Virtual address of the last accepted request if it faulted, else zero |

## Verification
Several properties are checked on every cycle:
- a user-mode access to the upper half always faults with a zero address;
- kernel-mode requests never fault;
- the uncached alias never reports a cacheable access;
- both kernel aliases keep the low 29 address bits and clear the top three;
- a stalled result stays stable;
- the captured fault address changes only when a request is accepted.

The exact relocation arithmetic of each segment can only be shown by the bench's vectors and directed scenarios. The same holds for the wrap of the offset, the equality of paired alias addresses, the reset state, and the one-cycle spacing of back-to-back results.

// File: rtl/segx_pkg.sv
package segx_pkg;

  localparam int unsigned VA_W     = 32;
  localparam int unsigned SEG_BITS = 3;

  typedef enum logic [2:0] {
    SEG_USER = 3'd0,
    SEG_K0   = 3'd1,
    SEG_K1   = 3'd2,
    SEG_K2   = 3'd3,
    SEG_K3   = 3'd4
  } seg_e;

  typedef struct packed {
    logic [VA_W-1:0] paddr;
    logic            cacheable;
    logic            fault;
  } xlate_t;

  // Classify a virtual address by its top three bits.
  function automatic seg_e seg_classify(input logic [VA_W-1:0] va);
    logic [SEG_BITS-1:0] top;
    top = va[VA_W-1 -: SEG_BITS];
    if (!top[2]) return SEG_USER;
    case (top[1:0])
      2'b00:   return SEG_K0;
      2'b01:   return SEG_K1;
      2'b10:   return SEG_K2;
      default: return SEG_K3;
    endcase
  endfunction

  // Kernel alias segments: drop the segment-select bits.
  function automatic logic [VA_W-1:0] kseg_strip(input logic [VA_W-1:0] va);
    return {{SEG_BITS{1'b0}}, va[VA_W-SEG_BITS-1:0]};
  endfunction

  // User segment: relocate by a fixed offset, wrapping modulo 2^VA_W.
  function automatic logic [VA_W-1:0] user_map(input logic [VA_W-1:0] va,
                                               input logic [VA_W-1:0] off);
    return va + off;
  endfunction

endpackage

// File: rtl/segx_decode.sv
module segx_decode
  import segx_pkg::*;
#(
  parameter logic [VA_W-1:0] USER_OFFSET = 32'h4000_0000
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            user_mode,
  output xlate_t          result
);

  seg_e seg;
  logic priv_trap;

  always_comb begin
    seg       = seg_classify(vaddr);
    priv_trap = user_mode && (seg != SEG_USER);
    result    = '0;
    unique case (seg)
      SEG_USER: begin
        result.paddr     = user_map(vaddr, USER_OFFSET);
        result.cacheable = 1'b1;
      end
      SEG_K0: begin
        result.paddr     = kseg_strip(vaddr);
        result.cacheable = 1'b1;
      end
      SEG_K1: begin
        result.paddr     = kseg_strip(vaddr);
        result.cacheable = 1'b0;
      end
      default: begin
        result.paddr     = vaddr;
        result.cacheable = 1'b1;
      end
    endcase
    if (priv_trap) begin
      result       = '0;
      result.fault = 1'b1;
    end
  end

endmodule

// File: rtl/segx_hold_stage.sv
module segx_hold_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic in_fire;
  logic out_fire;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

endmodule

// File: rtl/segx_translator.sv
module segx_translator
  import segx_pkg::*;
#(
  parameter logic [VA_W-1:0] USER_OFFSET = 32'h4000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_user,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_cacheable,
  output logic            rsp_fault,
  output logic [VA_W-1:0] fault_vaddr
);

  localparam int unsigned RES_W = $bits(xlate_t);

  xlate_t dec_res;
  xlate_t out_res;
  logic   req_fire;

  segx_decode #(.USER_OFFSET(USER_OFFSET)) u_decode (
    .vaddr     (req_vaddr),
    .user_mode (req_user),
    .result    (dec_res)
  );

  segx_hold_stage #(.W(RES_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (dec_res),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (out_res)
  );

  assign req_fire      = req_valid && req_ready;
  assign rsp_paddr     = out_res.paddr;
  assign rsp_cacheable = out_res.cacheable;
  assign rsp_fault     = out_res.fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_vaddr <= '0;
    end else if (req_fire) begin
      fault_vaddr <= dec_res.fault ? req_vaddr : '0;
    end
  end

  // R7
  user_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_user && req_vaddr[VA_W-1]
      |=> rsp_fault && (rsp_paddr == '0) && !rsp_cacheable);

  // R8
  kernel_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && (!req_user || !req_vaddr[VA_W-1]) |=> !rsp_fault);

  // R4
  k1_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_user && (req_vaddr[VA_W-1 -: SEG_BITS] == 3'b101)
      |=> !rsp_cacheable);

  // R5
  alias_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_user && (req_vaddr[VA_W-1 -: 2] == 2'b10)
      |=> (rsp_paddr[VA_W-1 -: SEG_BITS] == '0)
          && (rsp_paddr[VA_W-SEG_BITS-1:0] == $past(req_vaddr[VA_W-SEG_BITS-1:0])));

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> $stable(fault_vaddr));

endmodule

// File: tb/tb_segx_translator.sv
`timescale 1ns/1ps
module tb_segx_translator;

  typedef struct packed {
    logic        user;
    logic [31:0] va;
    logic [31:0] pa;
    logic        c;
    logic        f;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_1234, 32'h4000_1234, 1'b1, 1'b0},  // R2 kernel, user seg
    '{1'b1, 32'h7FFF_FFFC, 32'hBFFF_FFFC, 1'b1, 1'b0},  // R2 R8 user
    '{1'b0, 32'h8000_0100, 32'h0000_0100, 1'b1, 1'b0},  // R3
    '{1'b0, 32'hA000_0100, 32'h0000_0100, 1'b0, 1'b0},  // R4 R5
    '{1'b0, 32'h9FC0_0000, 32'h1FC0_0000, 1'b1, 1'b0},  // R3
    '{1'b0, 32'hBFC0_0000, 32'h1FC0_0000, 1'b0, 1'b0},  // R4 R5
    '{1'b0, 32'hBF88_6000, 32'h1F88_6000, 1'b0, 1'b0},  // R4
    '{1'b0, 32'hC000_0040, 32'hC000_0040, 1'b1, 1'b0},  // R6
    '{1'b0, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 1'b1, 1'b0},  // R6
    '{1'b1, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1},  // R7
    '{1'b1, 32'hA000_0010, 32'h0000_0000, 1'b0, 1'b1},  // R7
    '{1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1},  // R7
    '{1'b1, 32'h0000_0000, 32'h4000_0000, 1'b1, 1'b0},  // R2 R8
    '{1'b0, 32'hE000_0000, 32'hE000_0000, 1'b1, 1'b0}   // R6 R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_user;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_ready, rsp_cacheable, rsp_fault;
  logic [31:0] rsp_paddr, fault_vaddr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  segx_translator dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
    .rsp_fault(rsp_fault), .fault_vaddr(fault_vaddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic [31:0] pa, input logic c, input logic f);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " paddr"}, rsp_paddr, pa);
    chk({tag, " cacheable"}, {31'd0, rsp_cacheable}, {31'd0, c});
    chk({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, f});
  endtask

  // Single request, consumer ready; result checked one cycle later.
  task automatic apply(input logic u, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_user = u; req_vaddr = va; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_user = 1'b0; req_vaddr = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 fault_vaddr", fault_vaddr, 32'd0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].user, VEC[i].va);
      check_out($sformatf("vec%0d R2-8", i), VEC[i].pa, VEC[i].c, VEC[i].f);
      chk($sformatf("vec%0d R11", i), fault_vaddr, VEC[i].f ? VEC[i].va : 32'd0);
    end

    // R5 alias pair: same low bits through both kernel aliases
    begin
      logic [31:0] p0;
      apply(1'b0, 32'h8123_4568); p0 = rsp_paddr;
      apply(1'b0, 32'hA123_4568);
      chk("R5 alias equal", rsp_paddr, p0);
      chk("R5 alias value", p0, 32'h0123_4568);
    end

    // R10 back-to-back
    @(negedge clk);
    rsp_ready = 1'b1; req_user = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'h0000_0010;
    @(negedge clk);
    check_out("R10 b2b0", 32'h4000_0010, 1'b1, 1'b0);
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    req_vaddr = 32'hC000_0000;
    @(negedge clk);
    check_out("R10 b2b1", 32'hC000_0000, 1'b1, 1'b0);
    req_vaddr = 32'hA000_0044;
    @(negedge clk);
    check_out("R10 b2b2", 32'h0000_0044, 1'b0, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {31'd0, rsp_valid}, 32'd0);

    // R9 stall and hold
    req_valid = 1'b1; req_vaddr = 32'h8000_0200; rsp_ready = 1'b0;
    @(negedge clk);
    check_out("R9 first", 32'h0000_0200, 1'b1, 1'b0);
    chk("R9 ready low", {31'd0, req_ready}, 32'd0);
    req_vaddr = 32'hA000_0300;
    @(negedge clk);
    check_out("R9 held", 32'h0000_0200, 1'b1, 1'b0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check_out("R9 next", 32'h0000_0300, 1'b0, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 empty", {31'd0, rsp_valid}, 32'd0);

    // R11 capture, hold while idle, clear on clean request
    apply(1'b1, 32'hDEAD_BEE0);
    chk("R11 capture", fault_vaddr, 32'hDEAD_BEE0);
    repeat (3) @(negedge clk);
    chk("R11 hold", fault_vaddr, 32'hDEAD_BEE0);
    apply(1'b0, 32'h8000_0000);
    chk("R11 clear", fault_vaddr, 32'd0);
    chk("R8 kernel", {31'd0, rsp_fault}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule